// File: doc/BRIEF.md
# Character Display Host Command Interface

This block sits between a host bus and the storage of a two-line character display controller. On each synchronised strobe it looks at the register-select line, the read/write line and an 8-bit data bus, and turns them into one of four actions: load a pattern-RAM address, load a text-RAM address, return a status byte, or write a data byte. Only one address counter exists. The last address command decides whether that counter points into the 64-byte character pattern RAM or into the text RAM. The text RAM has two rows of 40 cells, at 00H–27H and 40H–67H.

After every data write the counter moves by one. The direction comes from an entry-mode bit, which is loaded through its own input. The wrap rule depends on which RAM is selected. Every accepted address command or data write starts a busy window of fixed length. During that window further commands and writes are dropped. A status read returns the busy flag together with the counter at any time. Write enables, addresses and data for both RAMs, and the status byte, all come from registers.

Top module: `chardisp_host_if`

## Requirements
- R1: After reset the counter is 00H, the text RAM is selected, the direction is increment, busy is 0, both write enables are 0 and the status output is 00H.
- R2: A strobe with reg_sel=0, rd_wr=0 and bus_in in 40H–7FH, while not busy, loads bus_in[5:0] into the counter (bit 6 cleared) and selects the pattern RAM.
- R3: A strobe with reg_sel=0, rd_wr=0 and bus_in[7]=1, while not busy, loads bus_in[6:0] into the counter and selects the text RAM.
- R4: A strobe with reg_sel=1 and rd_wr=0, while not busy, raises the write enable of the selected RAM only, for exactly one cycle after the strobe edge. That write carries the pre-write counter as its address (low 6 bits for the pattern RAM) and all 8 bus bits as its data.
- R5: With the pattern RAM selected, each write moves the counter by one modulo 64: 3FH goes to 00H on increment, and 00H goes to 3FH on decrement.
- R6: With the text RAM selected, an increment goes 27H to 40H and 67H to 00H, and otherwise adds 1. A decrement goes 40H to 27H and 00H to 67H, and otherwise subtracts 1.
- R7: A strobe with reg_sel=0 and rd_wr=1 sets bus_out, from the next cycle, to {busy, counter} as they stood at the strobe edge (busy on bit 7). This read is served even while busy.
- R8: Each accepted address command or data write holds busy at 1 for exactly BUSY_CYCLES clock cycles, starting the cycle after the strobe.
- R9: An address command or data write strobed while busy produces no write enable and leaves the counter unchanged.
- R10: A strobe with reg_sel=0, rd_wr=0 and bus_in below 40H, or with reg_sel=1 and rd_wr=1, changes nothing and does not set busy.
- R11: A pulse on entry_set loads entry_inc into the direction register (1 = increment, 0 = decrement). Later writes step the counter in that direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| strobe | input | 1 | One-cycle bus transaction pulse, already synchronised |
| reg_sel | input | 1 | 0 selects command/status, 1 selects data |
| rd_wr | input | 1 | 1 = read, 0 = write |
| bus_in | input | 8 | Host data bus into the block |
| entry_set | input | 1 | Load pulse for the direction register |
| entry_inc | input | 1 | Direction value: 1 increment, 0 decrement |
| bus_out | output | 8 | Status byte {busy, counter} from the last status read |
| busy | output | 1 | Internal operation in progress |
| cg_we | output | 1 | Pattern RAM write enable |
| cg_addr | output | 6 | Pattern RAM write address |
| cg_wdata | output | 8 | Pattern RAM write data |
| dd_we | output | 1 | Text RAM write enable |
| dd_addr | output | 7 | Text RAM write address |
| dd_wdata | output | 8 | Text RAM write data |

## Verification
The pattern RAM is swept over all 64 load addresses in both directions. This separates a true modulo-64 wrap from a 7-bit wrap at 3FH and 00H. The text RAM is swept over all 80 valid cells in both directions, which shows whether the row-end jumps at 27H, 40H, 67H and 00H are taken or whether the counter runs straight through the gaps. Strobes placed inside the busy window and ignored code points are each followed by status reads. These reads tell a dropped transaction apart from one that quietly moved the counter, and they measure the busy window to the exact cycle.

// File: rtl/chardisp_pkg.sv
package chardisp_pkg;
  typedef enum logic [2:0] {
    OP_NONE,
    OP_SET_CG,
    OP_SET_DD,
    OP_STATUS,
    OP_WRITE
  } host_op_e;
endpackage

// File: rtl/chardisp_decode.sv
module chardisp_decode
  import chardisp_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              strobe,
  input  logic              reg_sel,
  input  logic              rd_wr,
  input  logic [DATA_W-1:0] bus_in,
  input  logic              busy,
  output host_op_e          op
);
  always_comb begin
    op = OP_NONE;
    if (strobe) begin
      if (!reg_sel && rd_wr) begin
        op = OP_STATUS;
      end else if (!busy && !rd_wr) begin
        if (reg_sel)                 op = OP_WRITE;
        else if (bus_in[DATA_W-1])   op = OP_SET_DD;
        else if (bus_in[DATA_W-2])   op = OP_SET_CG;
      end
    end
  end
endmodule

// File: rtl/chardisp_addr_ctr.sv
module chardisp_addr_ctr #(
  parameter int ADDR_W     = 7,
  parameter int CG_W       = 6,
  parameter int LINE_LEN   = 40,
  parameter int LINE2_BASE = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_cg,
  input  logic              load_dd,
  input  logic              step,
  input  logic              dir_inc,
  input  logic [ADDR_W-1:0] load_val,
  output logic [ADDR_W-1:0] ctr,
  output logic              sel_dd
);
  localparam logic [ADDR_W-1:0] L1_FIRST = '0;
  localparam logic [ADDR_W-1:0] L1_LAST  = ADDR_W'(LINE_LEN - 1);
  localparam logic [ADDR_W-1:0] L2_FIRST = ADDR_W'(LINE2_BASE);
  localparam logic [ADDR_W-1:0] L2_LAST  = ADDR_W'(LINE2_BASE + LINE_LEN - 1);

  logic [ADDR_W-1:0] dd_nxt;
  logic [CG_W-1:0]   cg_nxt;

  always_comb begin
    if (dir_inc) begin
      if (ctr == L1_LAST)       dd_nxt = L2_FIRST;
      else if (ctr == L2_LAST)  dd_nxt = L1_FIRST;
      else                      dd_nxt = ctr + 1'b1;
    end else begin
      if (ctr == L2_FIRST)      dd_nxt = L1_LAST;
      else if (ctr == L1_FIRST) dd_nxt = L2_LAST;
      else                      dd_nxt = ctr - 1'b1;
    end
    cg_nxt = dir_inc ? ctr[CG_W-1:0] + 1'b1 : ctr[CG_W-1:0] - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctr    <= '0;
      sel_dd <= 1'b1;
    end else if (load_dd) begin
      ctr    <= load_val;
      sel_dd <= 1'b1;
    end else if (load_cg) begin
      ctr    <= ADDR_W'(load_val[CG_W-1:0]);
      sel_dd <= 1'b0;
    end else if (step) begin
      ctr    <= sel_dd ? dd_nxt : ADDR_W'(cg_nxt);
    end
  end
endmodule

// File: rtl/chardisp_busy_timer.sv
module chardisp_busy_timer #(
  parameter int BUSY_CYCLES = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy
);
  localparam int CNT_W = $clog2(BUSY_CYCLES + 1);
  localparam logic [CNT_W-1:0] RELOAD = CNT_W'(BUSY_CYCLES - 1);

  logic [CNT_W-1:0] remain;

  always_ff @(posedge clk) begin
    if (rst) begin
      remain <= '0;
      busy   <= 1'b0;
    end else if (start) begin
      remain <= RELOAD;
      busy   <= 1'b1;
    end else if (remain != '0) begin
      remain <= remain - 1'b1;
    end else begin
      busy   <= 1'b0;
    end
  end
endmodule

// File: rtl/chardisp_host_if.sv
module chardisp_host_if
  import chardisp_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int CG_W        = 6,
  parameter int LINE_LEN    = 40,
  parameter int LINE2_BASE  = 64,
  parameter int BUSY_CYCLES = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              strobe,
  input  logic              reg_sel,
  input  logic              rd_wr,
  input  logic [DATA_W-1:0] bus_in,
  input  logic              entry_set,
  input  logic              entry_inc,
  output logic [DATA_W-1:0] bus_out,
  output logic              busy,
  output logic              cg_we,
  output logic [CG_W-1:0]   cg_addr,
  output logic [DATA_W-1:0] cg_wdata,
  output logic              dd_we,
  output logic [DATA_W-2:0] dd_addr,
  output logic [DATA_W-1:0] dd_wdata
);
  localparam int ADDR_W = DATA_W - 1;

  host_op_e          op;
  logic [ADDR_W-1:0] ctr;
  logic              sel_dd;
  logic              dir_inc;
  logic              accept;

  chardisp_decode #(.DATA_W(DATA_W)) u_decode (
    .strobe  (strobe),
    .reg_sel (reg_sel),
    .rd_wr   (rd_wr),
    .bus_in  (bus_in),
    .busy    (busy),
    .op      (op)
  );

  chardisp_addr_ctr #(
    .ADDR_W     (ADDR_W),
    .CG_W       (CG_W),
    .LINE_LEN   (LINE_LEN),
    .LINE2_BASE (LINE2_BASE)
  ) u_ctr (
    .clk      (clk),
    .rst      (rst),
    .load_cg  (op == OP_SET_CG),
    .load_dd  (op == OP_SET_DD),
    .step     (op == OP_WRITE),
    .dir_inc  (dir_inc),
    .load_val (bus_in[ADDR_W-1:0]),
    .ctr      (ctr),
    .sel_dd   (sel_dd)
  );

  assign accept = (op == OP_SET_CG) || (op == OP_SET_DD) || (op == OP_WRITE);

  chardisp_busy_timer #(.BUSY_CYCLES(BUSY_CYCLES)) u_busy (
    .clk   (clk),
    .rst   (rst),
    .start (accept),
    .busy  (busy)
  );

  always_ff @(posedge clk) begin
    if (rst) dir_inc <= 1'b1;
    else if (entry_set) dir_inc <= entry_inc;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_out  <= '0;
      cg_we    <= 1'b0;
      cg_addr  <= '0;
      cg_wdata <= '0;
      dd_we    <= 1'b0;
      dd_addr  <= '0;
      dd_wdata <= '0;
    end else begin
      cg_we <= (op == OP_WRITE) && !sel_dd;
      dd_we <= (op == OP_WRITE) && sel_dd;
      if (op == OP_WRITE) begin
        if (sel_dd) begin
          dd_addr  <= ctr;
          dd_wdata <= bus_in;
        end else begin
          cg_addr  <= ctr[CG_W-1:0];
          cg_wdata <= bus_in;
        end
      end
      if (op == OP_STATUS) bus_out <= {busy, ctr};
    end
  end
endmodule

// File: rtl/chardisp_host_if_chk.sv
module chardisp_host_if_chk #(
  parameter int DATA_W      = 8,
  parameter int BUSY_CYCLES = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              strobe,
  input logic              reg_sel,
  input logic              rd_wr,
  input logic [DATA_W-1:0] bus_out,
  input logic              busy,
  input logic              cg_we,
  input logic              dd_we
);
  localparam int LEN_W = $clog2(BUSY_CYCLES + 2) + 1;
  logic [LEN_W-1:0] busy_len;

  always_ff @(posedge clk) begin
    if (rst) busy_len <= '0;
    else if (busy) busy_len <= busy_len + 1'b1;
    else busy_len <= '0;
  end

  assert_one_we_R4: assert property (@(posedge clk) disable iff (rst)
    !(cg_we && dd_we));

  assert_we_source_R4: assert property (@(posedge clk) disable iff (rst)
    (cg_we || dd_we) |-> $past(strobe && reg_sel && !rd_wr && !busy));

  assert_busy_ignored_R9: assert property (@(posedge clk) disable iff (rst)
    (strobe && busy && !rd_wr) |=> !(cg_we || dd_we));

  assert_status_flag_R7: assert property (@(posedge clk) disable iff (rst)
    (strobe && !reg_sel && rd_wr) |=> (bus_out[DATA_W-1] == $past(busy)));

  assert_busy_start_R8: assert property (@(posedge clk) disable iff (rst)
    (strobe && !busy && reg_sel && !rd_wr) |=> busy);

  assert_busy_len_R8: assert property (@(posedge clk) disable iff (rst)
    busy_len <= LEN_W'(BUSY_CYCLES));
endmodule

bind chardisp_host_if chardisp_host_if_chk #(
  .DATA_W      (DATA_W),
  .BUSY_CYCLES (BUSY_CYCLES)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .strobe  (strobe),
  .reg_sel (reg_sel),
  .rd_wr   (rd_wr),
  .bus_out (bus_out),
  .busy    (busy),
  .cg_we   (cg_we),
  .dd_we   (dd_we)
);

// File: tb/chardisp_host_if_test.sv
module chardisp_host_if_test;
  localparam int BUSY_N = 3;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       strobe = 1'b0, reg_sel = 1'b0, rd_wr = 1'b0;
  logic [7:0] bus_in = '0;
  logic       entry_set = 1'b0, entry_inc = 1'b1;
  logic [7:0] bus_out;
  logic       busy, cg_we, dd_we;
  logic [5:0] cg_addr;
  logic [6:0] dd_addr;
  logic [7:0] cg_wdata, dd_wdata;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  chardisp_host_if #(.BUSY_CYCLES(BUSY_N)) uut (
    .clk(clk), .rst(rst), .strobe(strobe), .reg_sel(reg_sel), .rd_wr(rd_wr),
    .bus_in(bus_in), .entry_set(entry_set), .entry_inc(entry_inc),
    .bus_out(bus_out), .busy(busy), .cg_we(cg_we), .cg_addr(cg_addr),
    .cg_wdata(cg_wdata), .dd_we(dd_we), .dd_addr(dd_addr), .dd_wdata(dd_wdata)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // drive one strobe at a negedge; returns at the next negedge
  task automatic xact(input logic rs, input logic rw, input logic [7:0] d);
    reg_sel = rs; rd_wr = rw; bus_in = d; strobe = 1'b1;
    @(negedge clk);
    strobe = 1'b0;
  endtask

  task automatic wait_ready();
    while (busy) @(negedge clk);
  endtask

  task automatic status(output logic [7:0] v);
    xact(1'b0, 1'b1, 8'h00);
    v = bus_out;
  endtask

  task automatic set_dir(input logic inc);
    entry_inc = inc; entry_set = 1'b1;
    @(negedge clk);
    entry_set = 1'b0;
  endtask

  function automatic int dd_next(input int a, input bit inc);
    if (inc) return (a == 39) ? 64 : (a == 103) ? 0 : a + 1;
    return (a == 64) ? 39 : (a == 0) ? 103 : a - 1;
  endfunction

  function automatic int cg_next(input int a, input bit inc);
    return inc ? (a + 1) % 64 : (a + 63) % 64;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] s;
    int n;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 bus_out", bus_out, 0);
    check("R1 busy", busy, 0);
    check("R1 we", {cg_we, dd_we}, 0);
    status(s);
    check("R1 status", s, 8'h00);
    xact(1'b1, 1'b0, 8'h5A);
    check("R1 text selected", dd_we, 1);
    check("R1 addr", dd_addr, 0);
    wait_ready();
    status(s);
    check("R1 increment default", s, 8'h01);

    // R2 R5 R11: pattern RAM sweep, both directions
    for (int dir = 1; dir >= 0; dir--) begin
      set_dir(dir[0]);
      for (int a = 0; a < 64; a++) begin
        xact(1'b0, 1'b0, 8'(8'h40 | a));
        wait_ready();
        status(s);
        check("R2 cg load", s, a);
        xact(1'b1, 1'b0, 8'(a ^ 8'hA5));
        check("R4 cg_we", {cg_we, dd_we}, 2'b10);
        check("R4 cg_addr", cg_addr, a);
        check("R4 cg_wdata", cg_wdata, (a ^ 8'hA5) & 8'hFF);
        @(negedge clk);
        check("R4 single pulse", cg_we, 0);
        wait_ready();
        status(s);
        check("R5 cg step", s, cg_next(a, dir[0]));
      end
    end

    // R3 R6: text RAM sweep over valid cells, both directions
    for (int dir = 1; dir >= 0; dir--) begin
      set_dir(dir[0]);
      for (int i = 0; i < 80; i++) begin
        int a;
        a = (i < 40) ? i : 64 + i - 40;
        xact(1'b0, 1'b0, 8'(8'h80 | a));
        wait_ready();
        status(s);
        check("R3 dd load", s, a);
        xact(1'b1, 1'b0, 8'(i + 8'h20));
        check("R4 dd_we", {cg_we, dd_we}, 2'b01);
        check("R4 dd_addr", dd_addr, a);
        check("R4 dd_wdata", dd_wdata, i + 8'h20);
        wait_ready();
        status(s);
        check("R6 dd step", s, dd_next(a, dir[0]));
      end
    end
    set_dir(1'b1);

    // R8 busy length
    xact(1'b0, 1'b0, 8'h85);
    n = 0;
    while (busy) begin n++; @(negedge clk); end
    check("R8 busy cycles after command", n, BUSY_N);
    xact(1'b1, 1'b0, 8'h11);
    n = 0;
    while (busy) begin n++; @(negedge clk); end
    check("R8 busy cycles after write", n, BUSY_N);

    // R7 status while busy, R9 ignored while busy
    xact(1'b0, 1'b0, 8'h90);          // counter 10H, busy
    status(s);
    check("R7 status during busy", s, 8'h90);
    xact(1'b1, 1'b0, 8'hEE);          // dropped
    check("R9 no write while busy", {cg_we, dd_we}, 0);
    xact(1'b0, 1'b0, 8'h47);          // dropped
    wait_ready();
    status(s);
    check("R9 counter and selection unchanged", s, 8'h10);
    xact(1'b1, 1'b0, 8'h33);
    check("R9 still text RAM", dd_we, 1);
    wait_ready();

    // R10 ignored codes
    status(s);
    xact(1'b0, 1'b0, 8'h25);
    check("R10 low code no busy", busy, 0);
    xact(1'b1, 1'b1, 8'h00);
    check("R10 data read no busy", busy, 0);
    check("R10 no write", {cg_we, dd_we}, 0);
    begin
      logic [7:0] s2;
      status(s2);
      check("R10 counter unchanged", s2, s);
    end

    // R11 direction change mid-stream
    xact(1'b0, 1'b0, 8'h80); wait_ready();
    set_dir(1'b0);
    xact(1'b1, 1'b0, 8'h01); wait_ready();
    status(s);
    check("R11 decrement wraps 00H to 67H", s, 8'h67);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule